// File: doc/BRIEF.md
# Bus Endian Converter

This block sits between a 64-bit processor bus whose native byte order is most-significant-first and a 64-bit memory or I/O data path. When the processor runs a little-endian workload it scrambles the low three bits of every address according to the transfer size, and it places data on its byte lanes to match. This block undoes the address scramble and mirrors the byte lanes so that storage holds true little-endian data. When the big-endian mode is selected, addresses and data pass through without change.

The processor's current byte order cannot be seen from the bus, so software selects it by writing a single mode flop through a host I/O write to a fixed port. The same port reads the flop back. The address path is combinational. The write and read data paths each have one register stage that produces one cycle of latency, and a valid strobe travels with the data.

Top module: `endian_conv`

## Requirements
- R1: After reset the mode is big-endian (`le_mode` = 0), and both data valid outputs are 0.
- R2: With `le_mode` = 0, `mem_addr` equals `cpu_addr` for every transfer size.
- R3: With `le_mode` = 1, `mem_addr[2:0]` is `cpu_addr[2:0]` XOR a mask chosen by `cpu_size` (00 = 1 byte: 111, 01 = 2 bytes: 110, 10 = 4 bytes: 100, 11 = 8 bytes: 000).
- R4: Address bits above bit 2 always pass through unchanged.
- R5: A write beat with `cpu_wr_valid` = 1 appears on `mem_wr_data` with `mem_wr_valid` = 1 exactly one clock later. With `le_mode` = 0 the data is unchanged.
- R6: With `le_mode` = 1, write data byte `cpu_wr_data[8k+7:8k]` lands on `mem_wr_data[8(7-k)+7:8(7-k)]` for k = 0..7. Bit order inside a byte is kept.
- R7: A read beat from `mem_rd_data` with `mem_rd_valid` = 1 reaches `cpu_rd_data` with `cpu_rd_valid` = 1 one clock later. It uses the same lane mirror in little-endian mode and passes straight through in big-endian mode.
- R8: An I/O write (`io_wr` = 1) to address 0x0092 loads `le_mode` from `io_wdata[0]`, effective from the next clock.
- R9: The other write data bits at port 0x0092 are ignored, and writes to any other I/O address leave the mode unchanged.
- R10: `io_rdata` is `{7'b0, le_mode}` when `io_addr` = 0x0092 and zero at every other address.
- R11: In a cycle with no valid beat, each data output register keeps its previous value, and its valid output is 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| le_mode | output | 1 | Current byte-order mode, 1 = little-endian |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host I/O write strobe |
| io_wdata | input | 8 | Host I/O write data |
| io_rdata | output | 8 | Host I/O read data for the mode port |
| cpu_addr | input | 32 | Processor address |
| cpu_size | input | 2 | Transfer size code |
| mem_addr | output | 32 | Corrected address toward memory / I/O |
| cpu_wr_valid | input | 1 | Write data beat valid |
| cpu_wr_data | input | 64 | Write data from the processor |
| mem_wr_valid | output | 1 | Steered write data valid |
| mem_wr_data | output | 64 | Steered write data |
| mem_rd_valid | input | 1 | Read data beat valid |
| mem_rd_data | input | 64 | Read data from memory / I/O |
| cpu_rd_valid | output | 1 | Steered read data valid |
| cpu_rd_data | output | 64 | Steered read data toward the processor |

## Verification
The hardest situation to reach from the ports is a change of mode between data beats. Here the registered stage must apply the mode that holds at the capture edge, not the one written afterwards. The bench reaches it by issuing the mode write over the I/O port, then placing data beats on the cycles directly before and after the switch. It also sweeps all eight low address values, all four size codes and both modes, with random upper address bits. Further runs write ignored port bits and nearby port addresses, and then confirm through readback that the mode did not change.

// File: rtl/endian_conv_pkg.sv
package endian_conv_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'b00,
      SZ_HALF  = 2'b01,
      SZ_WORD  = 2'b10,
      SZ_DWORD = 2'b11
   } xfer_size_e;

   localparam int unsigned SIZE_W = 2;

endpackage

// File: rtl/endian_addr_xform.sv
module endian_addr_xform #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFS_W  = 3,
   parameter int unsigned SZ_W   = 2
) (
   input  logic              le_mode,
   input  logic [SZ_W-1:0]   size,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);

   localparam int unsigned MAX_CODE = (1 << SZ_W) - 1;

   if (OFS_W >= ADDR_W) begin : g_bad_ofs
      $error("endian_addr_xform: OFS_W must be below ADDR_W");
   end
   if (OFS_W > MAX_CODE) begin : g_bad_sz
      $error("endian_addr_xform: SZ_W too narrow to encode full-width size");
   end

   logic [OFS_W-1:0] flip_mask;

   // a bit of the offset flips when the transfer is narrower than 2**(k+1) bytes
   for (genvar k = 0; k < OFS_W; k++) begin : g_mask
      assign flip_mask[k] = le_mode & (size <= SZ_W'(k));
   end

   assign addr_out = {addr_in[ADDR_W-1:OFS_W], addr_in[OFS_W-1:0] ^ flip_mask};

endmodule

// File: rtl/endian_lane_steer.sv
module endian_lane_steer #(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned LANE_W    = 8,
   parameter bit          REG_STAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              le_mode,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   localparam int unsigned LANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : g_bad_w
      $error("endian_lane_steer: DATA_W must be a multiple of LANE_W");
   end
   if (LANES < 2) begin : g_bad_l
      $error("endian_lane_steer: at least two lanes required");
   end

   logic [DATA_W-1:0] steered;

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign steered[j*LANE_W +: LANE_W] = le_mode ?
         in_data[(LANES-1-j)*LANE_W +: LANE_W] : in_data[j*LANE_W +: LANE_W];
   end

   if (REG_STAGE) begin : g_reg
      logic              vld_q;
      logic [DATA_W-1:0] dat_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
         end else begin
            vld_q <= in_valid;
            if (in_valid) dat_q <= steered;
         end
      end

      assign out_valid = vld_q;
      assign out_data  = dat_q;

      // R5 / R7: valid follows its beat by exactly one clock
      a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      // R11: no beat, no valid and no data change
      a_r11_idle_valid: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      a_r11_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(out_data));
      // R6: top input lane lands in the bottom output lane in little-endian mode
      a_r6_mirror_edge: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && le_mode) |=>
            out_data[LANE_W-1:0] == $past(in_data[DATA_W-1 -: LANE_W]));
      // R5: straight through in big-endian mode
      a_r5_be_pass: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !le_mode) |=> out_data == $past(in_data));
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_data  = steered;
   end

endmodule

// File: rtl/endian_mode_reg.sv
module endian_mode_reg #(
   parameter int unsigned          IO_ADDR_W = 16,
   parameter int unsigned          IO_DATA_W = 8,
   parameter logic [IO_ADDR_W-1:0] MODE_PORT = 16'h0092,
   parameter int unsigned          MODE_BIT  = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IO_ADDR_W-1:0] io_addr,
   input  logic                 io_wr,
   input  logic [IO_DATA_W-1:0] io_wdata,
   output logic [IO_DATA_W-1:0] io_rdata,
   output logic                 le_mode
);

   if (MODE_BIT >= IO_DATA_W) begin : g_bad_bit
      $error("endian_mode_reg: MODE_BIT outside the I/O data width");
   end

   logic port_hit;
   logic mode_q;
   logic unused_wbits;

   assign port_hit     = (io_addr == MODE_PORT);
   assign unused_wbits = ^io_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n)                mode_q <= 1'b0;
      else if (io_wr && port_hit) mode_q <= io_wdata[MODE_BIT];
   end

   always_comb begin
      io_rdata = '0;
      if (port_hit) io_rdata[MODE_BIT] = mode_q;
   end

   assign le_mode = mode_q;

   // R8: a write to the port loads the selected bit
   a_r8_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && port_hit) |=> le_mode == $past(io_wdata[MODE_BIT]));
   // R9: anything else leaves the mode alone
   a_r9_mode_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && port_hit) |=> $stable(le_mode));
   // R10: readback is silent away from the port
   a_r10_rd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !port_hit |-> io_rdata == '0);

endmodule

// File: rtl/endian_conv.sv
module endian_conv #(
   parameter int unsigned     ADDR_W    = 32,
   parameter int unsigned     DATA_W    = 64,
   parameter int unsigned     LANE_W    = 8,
   parameter int unsigned     IO_ADDR_W = 16,
   parameter int unsigned     IO_DATA_W = 8,
   parameter logic [15:0]     MODE_PORT = 16'h0092,
   parameter bit              REG_STAGE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   output logic                 le_mode,
   input  logic [IO_ADDR_W-1:0] io_addr,
   input  logic                 io_wr,
   input  logic [IO_DATA_W-1:0] io_wdata,
   output logic [IO_DATA_W-1:0] io_rdata,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic [1:0]           cpu_size,
   output logic [ADDR_W-1:0]    mem_addr,
   input  logic                 cpu_wr_valid,
   input  logic [DATA_W-1:0]    cpu_wr_data,
   output logic                 mem_wr_valid,
   output logic [DATA_W-1:0]    mem_wr_data,
   input  logic                 mem_rd_valid,
   input  logic [DATA_W-1:0]    mem_rd_data,
   output logic                 cpu_rd_valid,
   output logic [DATA_W-1:0]    cpu_rd_data
);
   import endian_conv_pkg::*;

   localparam int unsigned LANES = DATA_W / LANE_W;
   localparam int unsigned OFS_W = $clog2(LANES);

   if (IO_ADDR_W > 16) begin : g_bad_io
      $error("endian_conv: MODE_PORT is 16 bits wide");
   end
   if ((1 << OFS_W) != LANES) begin : g_bad_lanes
      $error("endian_conv: lane count must be a power of two");
   end

   endian_mode_reg #(
      .IO_ADDR_W (IO_ADDR_W),
      .IO_DATA_W (IO_DATA_W),
      .MODE_PORT (MODE_PORT[IO_ADDR_W-1:0]),
      .MODE_BIT  (0)
   ) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_addr  (io_addr),
      .io_wr    (io_wr),
      .io_wdata (io_wdata),
      .io_rdata (io_rdata),
      .le_mode  (le_mode)
   );

   endian_addr_xform #(
      .ADDR_W (ADDR_W),
      .OFS_W  (OFS_W),
      .SZ_W   (SIZE_W)
   ) u_addr (
      .le_mode  (le_mode),
      .size     (cpu_size),
      .addr_in  (cpu_addr),
      .addr_out (mem_addr)
   );

   endian_lane_steer #(
      .DATA_W    (DATA_W),
      .LANE_W    (LANE_W),
      .REG_STAGE (REG_STAGE)
   ) u_wr_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .le_mode   (le_mode),
      .in_valid  (cpu_wr_valid),
      .in_data   (cpu_wr_data),
      .out_valid (mem_wr_valid),
      .out_data  (mem_wr_data)
   );

   endian_lane_steer #(
      .DATA_W    (DATA_W),
      .LANE_W    (LANE_W),
      .REG_STAGE (REG_STAGE)
   ) u_rd_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .le_mode   (le_mode),
      .in_valid  (mem_rd_valid),
      .in_data   (mem_rd_data),
      .out_valid (cpu_rd_valid),
      .out_data  (cpu_rd_data)
   );

   // R2: big-endian mode leaves the address untouched
   a_r2_be_addr: assert property (@(posedge clk) disable iff (!rst_n)
      !le_mode |-> mem_addr == cpu_addr);
   // R4: only the byte offset is ever altered
   a_r4_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      mem_addr[ADDR_W-1:OFS_W] == cpu_addr[ADDR_W-1:OFS_W]);
   // R3: full-width transfers are not scrambled; single bytes flip every offset bit
   a_r3_full_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (le_mode && cpu_size == SZ_DWORD) |-> mem_addr == cpu_addr);
   a_r3_byte_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (le_mode && cpu_size == SZ_BYTE) |-> mem_addr[OFS_W-1:0] == ~cpu_addr[OFS_W-1:0]);
   // R1: valids are low in the first cycle after reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!mem_wr_valid && !cpu_rd_valid && !le_mode));

endmodule

// File: tb/endian_conv_tb.sv
module endian_conv_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        le_mode;
   logic [15:0] io_addr;
   logic        io_wr;
   logic [7:0]  io_wdata;
   logic [7:0]  io_rdata;
   logic [31:0] cpu_addr;
   logic [1:0]  cpu_size;
   logic [31:0] mem_addr;
   logic        cpu_wr_valid;
   logic [63:0] cpu_wr_data;
   logic        mem_wr_valid;
   logic [63:0] mem_wr_data;
   logic        mem_rd_valid;
   logic [63:0] mem_rd_data;
   logic        cpu_rd_valid;
   logic [63:0] cpu_rd_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   endian_conv u_dut (
      .clk (clk), .rst_n (rst_n), .le_mode (le_mode),
      .io_addr (io_addr), .io_wr (io_wr), .io_wdata (io_wdata), .io_rdata (io_rdata),
      .cpu_addr (cpu_addr), .cpu_size (cpu_size), .mem_addr (mem_addr),
      .cpu_wr_valid (cpu_wr_valid), .cpu_wr_data (cpu_wr_data),
      .mem_wr_valid (mem_wr_valid), .mem_wr_data (mem_wr_data),
      .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data),
      .cpu_rd_valid (cpu_rd_valid), .cpu_rd_data (cpu_rd_data)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mirror(input logic [63:0] d);
      logic [63:0] r;
      for (int b = 0; b < 8; b++) r[8*b +: 8] = d[8*(7-b) +: 8];
      return r;
   endfunction

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      io_addr  = a;
      io_wdata = d;
      io_wr    = 1'b1;
      @(negedge clk);
      io_wr    = 1'b0;
      io_addr  = 16'h0000;
   endtask

   // one write beat and one read beat in the same cycle, checked a clock later
   task automatic data_beat(input logic [63:0] wd, input logic [63:0] rd, input bit le);
      logic [63:0] ew, er;
      ew = le ? mirror(wd) : wd;
      er = le ? mirror(rd) : rd;
      cpu_wr_valid = 1'b1; cpu_wr_data = wd;
      mem_rd_valid = 1'b1; mem_rd_data = rd;
      @(negedge clk);
      cpu_wr_valid = 1'b0; cpu_wr_data = ~wd;
      mem_rd_valid = 1'b0; mem_rd_data = ~rd;
      chk(mem_wr_valid === 1'b1, "R5 wr valid", {63'b0, mem_wr_valid}, 64'd1);
      chk(mem_wr_data === ew, le ? "R6 wr mirror" : "R5 wr pass", mem_wr_data, ew);
      chk(cpu_rd_valid === 1'b1, "R7 rd valid", {63'b0, cpu_rd_valid}, 64'd1);
      chk(cpu_rd_data === er, "R7 rd data", cpu_rd_data, er);
      @(negedge clk);
      chk(mem_wr_valid === 1'b0 && cpu_rd_valid === 1'b0, "R11 valid drop",
          {62'b0, mem_wr_valid, cpu_rd_valid}, 64'd0);
      chk(mem_wr_data === ew, "R11 wr hold", mem_wr_data, ew);
      chk(cpu_rd_data === er, "R11 rd hold", cpu_rd_data, er);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      io_addr = '0; io_wr = 1'b0; io_wdata = '0;
      cpu_addr = '0; cpu_size = '0;
      cpu_wr_valid = 1'b0; cpu_wr_data = '0;
      mem_rd_valid = 1'b0; mem_rd_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(le_mode === 1'b0, "R1 mode", {63'b0, le_mode}, 64'd0);
      chk(mem_wr_valid === 1'b0 && cpu_rd_valid === 1'b0, "R1 valids",
          {62'b0, mem_wr_valid, cpu_rd_valid}, 64'd0);
      io_addr = 16'h0092; #1;
      chk(io_rdata === 8'h00, "R10 reset readback", {56'b0, io_rdata}, 64'd0);

      // R2 / R3 / R4 address sweep in both modes
      for (int m = 0; m < 2; m++) begin
         io_write(16'h0092, m[7:0]);
         chk(le_mode === m[0], "R8 mode load", {63'b0, le_mode}, m);
         for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 8; a++) begin
               logic [31:0] up, ex;
               logic [2:0]  msk;
               up  = $urandom;
               msk = (m == 1) ? (3'(7) & ~3'((1 << s) - 1)) : 3'd0;
               cpu_addr = {up[31:3], a[2:0]};
               cpu_size = s[1:0];
               ex = {up[31:3], a[2:0] ^ msk};
               #1;
               chk(mem_addr === ex, m ? "R3 le addr" : "R2 be addr", {32'b0, mem_addr}, {32'b0, ex});
               chk(mem_addr[31:3] === up[31:3], "R4 upper bits",
                   {35'b0, mem_addr[31:3]}, {35'b0, up[31:3]});
            end
         end
         @(negedge clk);
      end

      // R5 R6 R7 R11 data patterns, big-endian then little-endian
      io_write(16'h0092, 8'h00);
      data_beat(64'h0011223344556677, 64'h8899AABBCCDDEEFF, 1'b0);
      data_beat(64'hF0E1D2C3B4A59687, 64'h0102030405060708, 1'b0);
      io_write(16'h0092, 8'h01);
      data_beat(64'h0011223344556677, 64'h8899AABBCCDDEEFF, 1'b1);
      data_beat(64'h80000000000000FF, 64'h00000000000000A5, 1'b1);
      for (int i = 0; i < 6; i++) begin
         logic [63:0] w, r;
         w = {$urandom, $urandom};
         r = {$urandom, $urandom};
         data_beat(w, r, 1'b1);
      end

      // mode switch right after a beat: beat uses the mode at its capture edge
      cpu_wr_valid = 1'b1; cpu_wr_data = 64'hA1B2C3D4E5F60718;
      io_addr = 16'h0092; io_wdata = 8'h00; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; cpu_wr_data = 64'h1122334455667788;
      chk(mem_wr_data === mirror(64'hA1B2C3D4E5F60718), "R6 capture mode",
          mem_wr_data, mirror(64'hA1B2C3D4E5F60718));
      @(negedge clk);
      cpu_wr_valid = 1'b0;
      chk(mem_wr_data === 64'h1122334455667788, "R5 after switch",
          mem_wr_data, 64'h1122334455667788);
      chk(le_mode === 1'b0, "R8 cleared", {63'b0, le_mode}, 64'd0);

      // R9 ignored bits and other addresses
      io_write(16'h0092, 8'hFE);
      chk(le_mode === 1'b0, "R9 upper bits ignored", {63'b0, le_mode}, 64'd0);
      io_write(16'h0093, 8'h01);
      chk(le_mode === 1'b0, "R9 other port", {63'b0, le_mode}, 64'd0);
      io_write(16'h0092, 8'hFF);
      chk(le_mode === 1'b1, "R8 set", {63'b0, le_mode}, 64'd1);
      io_write(16'h0192, 8'h00);
      chk(le_mode === 1'b1, "R9 alias port", {63'b0, le_mode}, 64'd1);
      io_write(16'h0091, 8'h00);
      chk(le_mode === 1'b1, "R9 lower port", {63'b0, le_mode}, 64'd1);

      // R10 readback
      io_addr = 16'h0092; #1;
      chk(io_rdata === 8'h01, "R10 readback set", {56'b0, io_rdata}, 64'd1);
      io_addr = 16'h0090; #1;
      chk(io_rdata === 8'h00, "R10 other addr", {56'b0, io_rdata}, 64'd0);
      io_addr = 16'h0000;
      @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule